// File: doc/BRIEF.md
# Two-Bit Burst Address Generator

This block produces the address sequence for a four-beat burst on a synchronous burst memory. A burst begins when either of two active-low address strobes is sampled low on a rising clock edge. One strobe comes from the processor and is honoured only while the chip-select input is high. The other comes from the memory controller and is always honoured. On that edge the external address is captured whole. The following beats are produced by an internal two-bit beat counter, which moves forward only on edges where the active-low advance input is low.

A static order input chooses how the low address bits follow the beat counter. In linear order the low bits are the captured low bits plus the beat count, modulo four. In interleaved order they are the captured low bits XOR the beat count. The upper address bits stay at the captured value for the whole burst. The outputs are the registered full address and the registered beat index. Both change on the same clock edge that samples the controlling inputs.

Top module: `burst_addr_gen`

## Requirements
- R1: A synchronous active-high reset sets the address output and the beat index to zero on the next rising edge.
- R2: When the processor strobe is low and chip select is high on a rising edge, that edge loads the address input into the address output and clears the beat index to 0. A load wins over advance.
- R3: When the controller strobe is low on a rising edge, that edge loads the address input and clears the beat index to 0, whatever the chip-select level.
- R4: When chip select is low, a low processor strobe has no effect. With advance high, the address and beat hold. With advance low, the burst steps as in R6.
- R5: When both strobes are low with chip select high, the edge performs a single load of the address input, with beat 0.
- R6: On an edge with no load and advance low, the beat index increments by one, modulo 4.
- R7: With the order input at 0 (linear), the address low two bits equal (captured low bits + beat) mod 4.
- R8: With the order input at 1 (interleaved), the address low two bits equal the captured low bits XOR beat.
- R9: Address bits above bit 1 keep the captured value until the next load.
- R10: An advance on beat 3 wraps the beat index to 0 and returns the address to the captured start address.
- R11: On an edge with no load and advance high, the address and beat hold (burst suspend).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset, active high |
| chip_sel | input | 1 | Qualifies the processor strobe, active high |
| cpu_strobe_n | input | 1 | Processor address strobe, active low |
| ctl_strobe_n | input | 1 | Controller address strobe, active low |
| adv_n | input | 1 | Burst advance, active low |
| order_xor | input | 1 | Beat order: 0 linear, 1 interleaved |
| addr_in | input | ADDR_W | External start address |
| addr_out | output | ADDR_W | Registered burst address |
| beat | output | BEAT_W | Registered beat index |

## Verification
A beat counter in the wrong state shows at the ports on the same edge. The beat output is wrong at once, and the low address bits then follow the wrong term in both orders. A corrupted captured base gives a wrong address on the first advance after the load, and at the latest when the burst wraps on the fourth advance and fails to return to the start address. A wrong load decision, such as honouring the processor strobe without chip select, shows on the edge itself as an address jump or a beat reset where a hold or a step was due.

// File: rtl/burst_pkg.sv
package burst_pkg;
  typedef enum logic {ORDER_LINEAR = 1'b0, ORDER_XOR = 1'b1} order_e;
endpackage

// File: rtl/burst_start_decode.sv
module burst_start_decode (
  input  logic clk,
  input  logic rst,
  input  logic chip_sel,
  input  logic cpu_strobe_n,
  input  logic ctl_strobe_n,
  output logic load
);
  logic cpu_take;
  logic ctl_take;

  // processor strobe is gated by chip select; controller strobe is not
  assign cpu_take = ~cpu_strobe_n & chip_sel;
  assign ctl_take = ~ctl_strobe_n;
  assign load     = cpu_take | ctl_take;

  // R4: ungated processor strobe alone never starts a burst
  p_cpu_gated_r4: assert property (@(posedge clk) disable iff (rst)
    (!chip_sel && ctl_strobe_n) |-> !load);
  // R3: controller strobe always starts a burst
  p_ctl_loads_r3: assert property (@(posedge clk) disable iff (rst)
    !ctl_strobe_n |-> load);
endmodule

// File: rtl/burst_beat_counter.sv
module burst_beat_counter #(
  parameter int BEAT_W = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic              step,
  output logic [BEAT_W-1:0] beat_q,
  output logic [BEAT_W-1:0] beat_nxt
);
  localparam logic [BEAT_W-1:0] ONE = BEAT_W'(1);

  always_comb begin
    if (load)      beat_nxt = '0;
    else if (step) beat_nxt = beat_q + ONE;
    else           beat_nxt = beat_q;
  end

  always_ff @(posedge clk) begin
    if (rst) beat_q <= '0;
    else     beat_q <= beat_nxt;
  end

  // R6: an advance without load moves the beat forward by one
  p_step_r6: assert property (@(posedge clk) disable iff (rst)
    (!load && step) |=> beat_q == $past(beat_q) + ONE);
  // R11: no load and no advance keeps the beat
  p_hold_r11: assert property (@(posedge clk) disable iff (rst)
    (!load && !step) |=> $stable(beat_q));
  // R2: a load restarts the beat at zero
  p_load_zero_r2: assert property (@(posedge clk) disable iff (rst)
    load |=> beat_q == '0);
endmodule

// File: rtl/burst_order_map.sv
module burst_order_map
  import burst_pkg::*;
#(
  parameter int BEAT_W = 2
) (
  input  logic [BEAT_W-1:0] base_low,
  input  logic [BEAT_W-1:0] beat,
  input  order_e            order,
  output logic [BEAT_W-1:0] low
);
  always_comb begin
    if (order == ORDER_XOR) low = base_low ^ beat;
    else                    low = base_low + beat;
  end
endmodule

// File: rtl/burst_addr_gen.sv
module burst_addr_gen
  import burst_pkg::*;
#(
  parameter int ADDR_W = 17,
  parameter int BEAT_W = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              chip_sel,
  input  logic              cpu_strobe_n,
  input  logic              ctl_strobe_n,
  input  logic              adv_n,
  input  logic              order_xor,
  input  logic [ADDR_W-1:0] addr_in,
  output logic [ADDR_W-1:0] addr_out,
  output logic [BEAT_W-1:0] beat
);
  localparam int HI_W = ADDR_W - BEAT_W;

  logic              load;
  logic              step;
  logic [BEAT_W-1:0] beat_nxt;
  logic [BEAT_W-1:0] base_low_q;
  logic [BEAT_W-1:0] mapped_low;
  order_e            order;

  assign step  = ~adv_n;
  assign order = order_e'(order_xor);

  burst_start_decode u_dec (
    .clk          (clk),
    .rst          (rst),
    .chip_sel     (chip_sel),
    .cpu_strobe_n (cpu_strobe_n),
    .ctl_strobe_n (ctl_strobe_n),
    .load         (load)
  );

  burst_beat_counter #(.BEAT_W(BEAT_W)) u_cnt (
    .clk      (clk),
    .rst      (rst),
    .load     (load),
    .step     (step),
    .beat_q   (beat),
    .beat_nxt (beat_nxt)
  );

  burst_order_map #(.BEAT_W(BEAT_W)) u_map (
    .base_low (base_low_q),
    .beat     (beat_nxt),
    .order    (order),
    .low      (mapped_low)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      base_low_q <= '0;
      addr_out   <= '0;
    end else if (load) begin
      base_low_q <= addr_in[BEAT_W-1:0];
      addr_out   <= addr_in;
    end else if (step) begin
      addr_out[BEAT_W-1:0] <= mapped_low;
    end
  end

  // R2: a load copies the input address on that edge
  p_load_addr_r2: assert property (@(posedge clk) disable iff (rst)
    load |=> addr_out == $past(addr_in));
  // R9: upper bits are frozen between loads
  p_upper_fixed_r9: assert property (@(posedge clk) disable iff (rst)
    !load |=> $stable(addr_out[ADDR_W-1:BEAT_W]));
  // R11: suspend keeps the whole address
  p_suspend_r11: assert property (@(posedge clk) disable iff (rst)
    (!load && adv_n) |=> $stable(addr_out));

  if (HI_W < 1) begin : g_bad_width
    initial $error("ADDR_W must exceed BEAT_W");
  end
endmodule

// File: tb/burst_addr_gen_bench.sv
module burst_addr_gen_bench;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 17;
  localparam int NV = 14;
  // fields: cpu_n, ctl_n, sel, adv_n, xor, addr, exp_addr, exp_beat, req
  localparam logic [44:0] VEC [NV] = '{
    {1'b0,1'b1,1'b1,1'b1,1'b0,17'h12346,17'h12346,2'd0,4'd2},  // R2 load
    {1'b1,1'b1,1'b1,1'b0,1'b0,17'h00000,17'h12347,2'd1,4'd7},  // R7 linear
    {1'b1,1'b1,1'b1,1'b0,1'b0,17'h00000,17'h12344,2'd2,4'd7},  // R7 linear
    {1'b1,1'b1,1'b1,1'b1,1'b0,17'h1FFFF,17'h12344,2'd2,4'd11}, // R11 suspend
    {1'b1,1'b1,1'b1,1'b0,1'b0,17'h00000,17'h12345,2'd3,4'd6},  // R6 step
    {1'b1,1'b1,1'b1,1'b0,1'b0,17'h00000,17'h12346,2'd0,4'd10}, // R10 wrap
    {1'b1,1'b0,1'b0,1'b1,1'b1,17'h0ABC5,17'h0ABC5,2'd0,4'd3},  // R3 ctl load
    {1'b1,1'b1,1'b1,1'b0,1'b1,17'h00000,17'h0ABC4,2'd1,4'd8},  // R8 xor
    {1'b1,1'b1,1'b1,1'b0,1'b1,17'h00000,17'h0ABC7,2'd2,4'd8},  // R8 xor
    {1'b1,1'b1,1'b1,1'b0,1'b1,17'h00000,17'h0ABC6,2'd3,4'd9},  // R9 upper
    {1'b0,1'b1,1'b0,1'b1,1'b1,17'h1FFFF,17'h0ABC6,2'd3,4'd4},  // R4 ignored
    {1'b0,1'b1,1'b0,1'b0,1'b1,17'h1FFFF,17'h0ABC5,2'd0,4'd4},  // R4 steps
    {1'b0,1'b0,1'b1,1'b0,1'b0,17'h00003,17'h00003,2'd0,4'd5},  // R5 both
    {1'b1,1'b1,1'b1,1'b0,1'b0,17'h1FFFF,17'h00000,2'd1,4'd9}   // R9 upper
  };

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          chip_sel = 1'b0;
  logic          cpu_strobe_n = 1'b1;
  logic          ctl_strobe_n = 1'b1;
  logic          adv_n = 1'b1;
  logic          order_xor = 1'b0;
  logic [AW-1:0] addr_in = '0;
  logic [AW-1:0] addr_out;
  logic [1:0]    beat;
  int total = 0;
  int bad = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  burst_addr_gen u_burst_addr_gen (
    .clk(clk), .rst(rst), .chip_sel(chip_sel), .cpu_strobe_n(cpu_strobe_n),
    .ctl_strobe_n(ctl_strobe_n), .adv_n(adv_n), .order_xor(order_xor),
    .addr_in(addr_in), .addr_out(addr_out), .beat(beat)
  );

  task automatic check(input int req, input logic [AW-1:0] ea, input logic [1:0] eb);
    total++;
    if (addr_out !== ea || beat !== eb) begin
      bad++;
      $display("FAIL R%0d addr=%h beat=%0d expected addr=%h beat=%0d",
               req, addr_out, beat, ea, eb);
    end
  endtask

  initial begin
    repeat (2) @(posedge clk);
    @(negedge clk) rst = 1'b0;
    check(1, '0, 2'd0); // R1 reset state
    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      {cpu_strobe_n, ctl_strobe_n, chip_sel, adv_n, order_xor, addr_in} = VEC[i][44:23];
      @(posedge clk);
      #1 check(int'(VEC[i][3:0]), VEC[i][22:6], VEC[i][5:4]);
    end
    // R10 full interleaved burst wraps to start
    @(negedge clk);
    {cpu_strobe_n, ctl_strobe_n, chip_sel, adv_n, order_xor, addr_in} = {5'b01101, 17'h15552};
    @(posedge clk);
    @(negedge clk);
    {cpu_strobe_n, ctl_strobe_n, adv_n} = 3'b110;
    repeat (4) @(posedge clk);
    #1 check(10, 17'h15552, 2'd0);
    // R1 reset mid-burst
    @(negedge clk) rst = 1'b1;
    @(posedge clk);
    #1 check(1, '0, 2'd0);
    @(negedge clk) rst = 1'b0;
    adv_n = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (2000) @(posedge clk);
    bad++;
    total++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule